// File: doc/BRIEF.md
# Trap Entry Controller

This block handles the single clock edge on which a small hart enters a trap. A one-cycle request presents a packed word holding a trap identifier and a cause code, together with the faulting PC, the faulting address, the faulting instruction and the privilege the hart is running at. From these the block picks the privilege that takes the trap, which is machine or user. It loads that level's exception PC, cause and trap-value registers and computes the next fetch address from that level's vector base. The new privilege and the redirect are registered on the same edge.

A breakpoint exception can divert into debug mode instead of a normal trap. This happens when the breakpoint-to-debug enable input is high and the debug option is built in. In that case the faulting address goes to a debug PC register, a small debug control field is rewritten, and the resulting privilege is the old privilege with a debug flag ORed on top. Synchronous exceptions raised below machine level can be handed down to user level through a per-cause delegation mask. Interrupts are always taken at machine level.

Top module: `trap_entry_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, `priv_o` is 3 (machine, debug flag clear), `redirect_vld` is 0, and the debug PC, the debug control state and all six level registers are 0.
- R2: `trap_word` holds the trap identifier in bits 15:0 (zero means synchronous exception, nonzero means interrupt) and the cause in bits 30:16. A one-cycle `trap_req` raises `redirect_vld` for exactly the following cycle, and every register update lands on that same edge. Without `trap_req`, no level register and no debug register changes.
- R3: An exception with cause 11 is recorded, and used for delegation, as cause 8 plus `cur_priv` (8 from user, 9 from supervisor, 11 from machine).
- R4: An exception is taken at user level (`priv_o` = 0, user registers written) when `cur_priv` is not 3 and the delegation mask bit indexed by the effective cause is 1. Every other non-debug trap, and every interrupt, is taken at machine level (`priv_o` = 3, machine registers written).
- R5: On a non-debug trap, the target level's exception PC takes `fault_pc`. Its cause register takes the effective cause in the low bits and the interrupt flag in bit 31.
- R6: The trap value for cause 2 is the full `fault_instr` when its bits 1:0 are 2'b11, and otherwise its low 16 bits zero-extended. For causes 0, 1, 4, 5, 6, 7, and for cause 3 without debug entry, the trap value is `fault_addr`. For every other cause and for interrupts it is 0.
- R7: A cause-3 exception with `dbg_brk_en` high enters debug mode. `dbg_pc` takes `fault_addr`, and the level registers keep their values. The debug control state has bits 8,7,6,1,0 cleared, then bit 6 and the privilege bits 1:0 = 3 set, and `priv_o` becomes `cur_priv | 4`. `dbg_csr` shows that state in bits 8:0 and the live `dbg_brk_en` in bit 15.
- R8: `redirect_pc` is the target level's vector base with bits 1:0 cleared (machine base on debug entry). When base bit 0 is 1 and the trap is an interrupt, 4 times the cause is added. Exceptions never get the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | One-cycle trap request |
| trap_word | input | 32 | Identifier [15:0], cause [30:16] |
| cur_priv | input | 2 | Privilege at the time of the trap |
| fault_pc | input | 32 | PC of the trapping instruction |
| fault_addr | input | 32 | Faulting address |
| fault_instr | input | 32 | Faulting instruction bits |
| deleg_mask | input | 32 | Per-cause user delegation mask |
| mvec | input | 32 | Machine vector base, bit 0 selects vectored |
| uvec | input | 32 | User vector base, bit 0 selects vectored |
| dbg_brk_en | input | 1 | Breakpoint enters debug mode |
| redirect_vld | output | 1 | Next fetch PC valid |
| redirect_pc | output | 32 | Next fetch PC |
| priv_o | output | 3 | New privilege, bit 2 = debug flag |
| m_epc | output | 32 | Machine exception PC |
| m_cause | output | 32 | Machine cause |
| m_tval | output | 32 | Machine trap value |
| u_epc | output | 32 | User exception PC |
| u_cause | output | 32 | User cause |
| u_tval | output | 32 | User trap value |
| dbg_pc | output | 32 | Debug PC |
| dbg_csr | output | 32 | Debug control view |

## Verification
Exceptions with causes 0 to 15 are swept from user, supervisor and machine privilege. Two complementary delegation masks mean every cause is seen both delegated and kept at machine level, and running each cause from machine level shows that the mask is ignored there. Each sweep is repeated with the debug enable low and high, which separates debug entry from an ordinary breakpoint. Full and compressed instruction encodings are alternated to split the two illegal-instruction trap values. Interrupts of every cause are sent with a direct and with a vectored machine base, and a user vector that is itself vectored, which shows the offset applies only to interrupts.

// File: rtl/trap_entry_pkg.sv
// Shared encodings for the trap entry controller.
// Assumes privilege is carried as a 2-bit level, plus a separate debug flag.
package trap_entry_pkg;

    typedef enum logic [1:0] {
        PRV_USER  = 2'd0,
        PRV_SUPER = 2'd1,
        PRV_MACH  = 2'd3
    } prv_e;

    localparam logic [2:0] DBG_MODE_FLAG  = 3'b100;

    localparam int CAUSE_ILLEGAL  = 2;
    localparam int CAUSE_BRK      = 3;
    localparam int CAUSE_ECALL_U  = 8;
    localparam int CAUSE_ECALL_IN = 11;

    localparam logic [8:0] DCTL_CLR_MASK = 9'h1C3;
    localparam logic [8:0] DCTL_SET_BITS = 9'h043;

endpackage

// File: rtl/trap_classify.sv
// Combinational decode of a trap request.
// Splits the request word, adjusts environment-call causes, decides delegation
// and debug entry, and selects the trap value.
// Assumes XLEN >= 32 and CAUSE_W wider than the delegation index.
module trap_classify
    import trap_entry_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int ID_W     = 16,
    parameter int CAUSE_W  = 15,
    parameter int DELEG_W  = 32,
    parameter bit DEBUG_EN = 1'b1
) (
    input  logic [ID_W+CAUSE_W:0] trap_word,
    input  logic [1:0]            cur_priv,
    input  logic [DELEG_W-1:0]    deleg_mask,
    input  logic                  dbg_brk_en,
    input  logic [XLEN-1:0]       fault_addr,
    input  logic [31:0]           fault_instr,
    output logic                  is_irq,
    output logic [CAUSE_W-1:0]    cause_eff,
    output logic                  tgt_user,
    output logic                  dbg_enter,
    output logic [XLEN-1:0]       tval
);

    localparam int IDX_W = $clog2(DELEG_W);

    logic [ID_W-1:0]    trap_id;
    logic [CAUSE_W-1:0] cause_raw;
    logic               deleg_hit;

    // Field split and environment-call cause rewrite.
    always_comb begin
        trap_id   = trap_word[ID_W-1:0];
        cause_raw = trap_word[ID_W+CAUSE_W-1:ID_W];
        is_irq    = (trap_id != '0);
        if (!is_irq && cause_raw == CAUSE_W'(CAUSE_ECALL_IN))
            cause_eff = CAUSE_W'(CAUSE_ECALL_U) + CAUSE_W'(cur_priv);
        else
            cause_eff = cause_raw;
    end

    // Delegation lookup, guarded against causes beyond the mask width.
    always_comb begin
        deleg_hit = ((cause_eff >> IDX_W) == '0) && deleg_mask[cause_eff[IDX_W-1:0]];
        tgt_user  = !is_irq && (cur_priv != PRV_MACH) && deleg_hit;
    end

    // Debug entry decision, present only when the debug option is built.
    if (DEBUG_EN) begin : g_dbg
        assign dbg_enter = !is_irq && (cause_eff == CAUSE_W'(CAUSE_BRK)) && dbg_brk_en;
    end else begin : g_nodbg
        logic unused_dbg_en;
        assign unused_dbg_en = dbg_brk_en;
        assign dbg_enter     = 1'b0;
    end

    // Trap value selection by cause.
    always_comb begin
        tval = '0;
        if (!is_irq) begin
            if (cause_eff == CAUSE_W'(CAUSE_ILLEGAL))
                tval = (fault_instr[1:0] == 2'b11) ? XLEN'(fault_instr)
                                                   : XLEN'(fault_instr[15:0]);
            else if (cause_eff == CAUSE_W'(CAUSE_BRK))
                tval = dbg_enter ? '0 : fault_addr;
            else if (cause_eff < CAUSE_W'(8))
                tval = fault_addr;
        end
    end

endmodule

// File: rtl/trap_level_bank.sv
// Exception PC, cause and trap-value registers of one privilege level.
// Assumes a single write strobe that loads all three together.
module trap_level_bank #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [XLEN-1:0] epc_in,
    input  logic [XLEN-1:0] cause_in,
    input  logic [XLEN-1:0] tval_in,
    output logic [XLEN-1:0] epc,
    output logic [XLEN-1:0] cause,
    output logic [XLEN-1:0] tval
);

    // Load the three registers on a write, clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc   <= '0;
            cause <= '0;
            tval  <= '0;
        end else if (wr) begin
            epc   <= epc_in;
            cause <= cause_in;
            tval  <= tval_in;
        end
    end

endmodule

// File: rtl/trap_debug_state.sv
// Debug PC and the low debug-control field updated on debug entry.
// Assumes the enable bit lives outside this block and is only reflected here.
module trap_debug_state
    import trap_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enter,
    input  logic [XLEN-1:0] addr,
    input  logic            brk_en,
    output logic [XLEN-1:0] dpc,
    output logic [31:0]     dctl
);

    logic [8:0] dctl_low;

    // Capture the return address and rewrite the control field on entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dpc      <= '0;
            dctl_low <= '0;
        end else if (enter) begin
            dpc      <= addr;
            dctl_low <= (dctl_low & ~DCTL_CLR_MASK) | DCTL_SET_BITS;
        end
    end

    // Present the control view with the live enable in bit 15.
    always_comb dctl = {16'b0, brk_en, 6'b0, dctl_low};

endmodule

// File: rtl/trap_vector_calc.sv
// Next fetch address from a vector base.
// Assumes base bit 0 selects vectored mode; bit 1 is ignored.
module trap_vector_calc #(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 15
) (
    input  logic [XLEN-1:0]    base,
    input  logic               is_irq,
    input  logic [CAUSE_W-1:0] cause,
    output logic [XLEN-1:0]    target
);

    logic [XLEN-1:0] offset;

    // Aligned base plus the per-cause slot for vectored interrupts.
    always_comb begin
        offset = (is_irq && base[0]) ? XLEN'({cause, 2'b00}) : '0;
        target = {base[XLEN-1:2], 2'b00} + offset;
    end

endmodule

// File: rtl/trap_entry_ctrl.sv
// Trap entry controller top.
// Takes a one-cycle trap request and, on the following edge, updates the
// target level's registers, the debug state, the privilege and the redirect.
// Assumes two stored levels (user and machine); supervisor traps delegate to user.
module trap_entry_ctrl
    import trap_entry_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int ID_W     = 16,
    parameter int CAUSE_W  = 15,
    parameter int DELEG_W  = 32,
    parameter bit DEBUG_EN = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  trap_req,
    input  logic [ID_W+CAUSE_W:0] trap_word,
    input  logic [1:0]            cur_priv,
    input  logic [XLEN-1:0]       fault_pc,
    input  logic [XLEN-1:0]       fault_addr,
    input  logic [31:0]           fault_instr,
    input  logic [DELEG_W-1:0]    deleg_mask,
    input  logic [XLEN-1:0]       mvec,
    input  logic [XLEN-1:0]       uvec,
    input  logic                  dbg_brk_en,
    output logic                  redirect_vld,
    output logic [XLEN-1:0]       redirect_pc,
    output logic [2:0]            priv_o,
    output logic [XLEN-1:0]       m_epc,
    output logic [XLEN-1:0]       m_cause,
    output logic [XLEN-1:0]       m_tval,
    output logic [XLEN-1:0]       u_epc,
    output logic [XLEN-1:0]       u_cause,
    output logic [XLEN-1:0]       u_tval,
    output logic [XLEN-1:0]       dbg_pc,
    output logic [31:0]           dbg_csr
);

    localparam int NUM_LVL = 2;

    logic               is_irq;
    logic [CAUSE_W-1:0] cause_eff;
    logic               tgt_user;
    logic               dbg_enter;
    logic [XLEN-1:0]    tval;
    logic [XLEN-1:0]    cause_word;
    logic [XLEN-1:0]    vec_base;
    logic [XLEN-1:0]    next_pc;
    logic [2:0]         priv_next;

    logic [XLEN-1:0] bk_epc   [NUM_LVL];
    logic [XLEN-1:0] bk_cause [NUM_LVL];
    logic [XLEN-1:0] bk_tval  [NUM_LVL];

    trap_classify #(
        .XLEN(XLEN), .ID_W(ID_W), .CAUSE_W(CAUSE_W),
        .DELEG_W(DELEG_W), .DEBUG_EN(DEBUG_EN)
    ) u_cls (
        .trap_word  (trap_word),
        .cur_priv   (cur_priv),
        .deleg_mask (deleg_mask),
        .dbg_brk_en (dbg_brk_en),
        .fault_addr (fault_addr),
        .fault_instr(fault_instr),
        .is_irq     (is_irq),
        .cause_eff  (cause_eff),
        .tgt_user   (tgt_user),
        .dbg_enter  (dbg_enter),
        .tval       (tval)
    );

    // Cause word: interrupt flag on top, cause code at the bottom.
    always_comb begin
        cause_word                = '0;
        cause_word[XLEN-1]        = is_irq;
        cause_word[CAUSE_W-1:0]   = cause_eff;
    end

    // Vector base and new privilege for the chosen target.
    always_comb begin
        vec_base = (tgt_user && !dbg_enter) ? uvec : mvec;
        if (dbg_enter)
            priv_next = DBG_MODE_FLAG | {1'b0, cur_priv};
        else if (tgt_user)
            priv_next = {1'b0, PRV_USER};
        else
            priv_next = {1'b0, PRV_MACH};
    end

    trap_vector_calc #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_vec (
        .base  (vec_base),
        .is_irq(is_irq),
        .cause (cause_eff),
        .target(next_pc)
    );

    // One register bank per stored level: index 0 user, last index machine.
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        localparam bit IS_MACH = (g == NUM_LVL - 1);
        logic wr;
        assign wr = trap_req && !dbg_enter && (tgt_user == !IS_MACH);
        trap_level_bank #(.XLEN(XLEN)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (wr),
            .epc_in  (fault_pc),
            .cause_in(cause_word),
            .tval_in (tval),
            .epc     (bk_epc[g]),
            .cause   (bk_cause[g]),
            .tval    (bk_tval[g])
        );
    end

    assign u_epc   = bk_epc[0];
    assign u_cause = bk_cause[0];
    assign u_tval  = bk_tval[0];
    assign m_epc   = bk_epc[NUM_LVL-1];
    assign m_cause = bk_cause[NUM_LVL-1];
    assign m_tval  = bk_tval[NUM_LVL-1];

    trap_debug_state #(.XLEN(XLEN)) u_dbg (
        .clk   (clk),
        .rst_n (rst_n),
        .enter (trap_req && dbg_enter),
        .addr  (fault_addr),
        .brk_en(dbg_brk_en),
        .dpc   (dbg_pc),
        .dctl  (dbg_csr)
    );

    // Privilege and redirect commit on the request edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv_o       <= {1'b0, PRV_MACH};
            redirect_vld <= 1'b0;
            redirect_pc  <= '0;
        end else begin
            redirect_vld <= trap_req;
            if (trap_req) begin
                priv_o      <= priv_next;
                redirect_pc <= next_pc;
            end
        end
    end

endmodule

// File: rtl/trap_entry_checker.sv
// Temporal checks on the trap entry controller ports, attached by bind.
// Assumes synchronous active-low reset; all properties are disabled in reset.
module trap_entry_checker #(
    parameter int XLEN     = 32,
    parameter int ID_W     = 16,
    parameter int CAUSE_W  = 15,
    parameter bit DEBUG_EN = 1'b1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  trap_req,
    input logic [ID_W+CAUSE_W:0] trap_word,
    input logic [1:0]            cur_priv,
    input logic [XLEN-1:0]       fault_addr,
    input logic                  dbg_brk_en,
    input logic                  redirect_vld,
    input logic [XLEN-1:0]       redirect_pc,
    input logic [2:0]            priv_o,
    input logic [XLEN-1:0]       m_epc,
    input logic [XLEN-1:0]       m_cause,
    input logic [XLEN-1:0]       u_epc,
    input logic [XLEN-1:0]       dbg_pc
);

    logic is_exc;
    logic brk_dbg;
    assign is_exc  = (trap_word[ID_W-1:0] == '0);
    assign brk_dbg = DEBUG_EN && is_exc && dbg_brk_en &&
                     (trap_word[ID_W+CAUSE_W-1:ID_W] == CAUSE_W'(3));

    assert_redirect_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> redirect_vld);

    assert_no_spurious_redirect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |=> !redirect_vld);

    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |=> ($stable(m_epc) && $stable(u_epc) && $stable(dbg_pc)));

    assert_target_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_vld |-> (redirect_pc[1:0] == 2'b00));

    assert_irq_to_machine_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !is_exc) |=> (priv_o == 3'd3 && m_cause[XLEN-1]));

    assert_machine_no_deleg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && is_exc && cur_priv == 2'd3 && !brk_dbg) |=> (priv_o == 3'd3));

    assert_debug_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && brk_dbg) |=> (priv_o[2] && dbg_pc == $past(fault_addr) &&
                                   $stable(m_epc) && $stable(u_epc)));

endmodule

bind trap_entry_ctrl trap_entry_checker #(
    .XLEN(XLEN), .ID_W(ID_W), .CAUSE_W(CAUSE_W), .DEBUG_EN(DEBUG_EN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trap_req    (trap_req),
    .trap_word   (trap_word),
    .cur_priv    (cur_priv),
    .fault_addr  (fault_addr),
    .dbg_brk_en  (dbg_brk_en),
    .redirect_vld(redirect_vld),
    .redirect_pc (redirect_pc),
    .priv_o      (priv_o),
    .m_epc       (m_epc),
    .m_cause     (m_cause),
    .u_epc       (u_epc),
    .dbg_pc      (dbg_pc)
);

// File: tb/sim_trap_entry_ctrl.sv
// Sweeping bench for the trap entry controller with an arithmetic reference model.
module sim_trap_entry_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_req = 1'b0;
    logic [31:0] trap_word = '0;
    logic [1:0]  cur_priv = 2'd3;
    logic [31:0] fault_pc = '0, fault_addr = '0, fault_instr = '0;
    logic [31:0] deleg_mask = '0, mvec = '0, uvec = '0;
    logic        dbg_brk_en = 1'b0;
    logic        redirect_vld;
    logic [31:0] redirect_pc;
    logic [2:0]  priv_o;
    logic [31:0] m_epc, m_cause, m_tval, u_epc, u_cause, u_tval, dbg_pc, dbg_csr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int seq = 0;

    logic [31:0] e_m_epc = '0, e_m_cause = '0, e_m_tval = '0;
    logic [31:0] e_u_epc = '0, e_u_cause = '0, e_u_tval = '0;
    logic [31:0] e_dpc = '0, e_pc = '0;
    logic [8:0]  e_dlow = '0;
    logic [2:0]  e_priv = 3'd3;

    always #5 clk = ~clk;

    trap_entry_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_word(trap_word),
        .cur_priv(cur_priv), .fault_pc(fault_pc), .fault_addr(fault_addr),
        .fault_instr(fault_instr), .deleg_mask(deleg_mask), .mvec(mvec), .uvec(uvec),
        .dbg_brk_en(dbg_brk_en), .redirect_vld(redirect_vld), .redirect_pc(redirect_pc),
        .priv_o(priv_o), .m_epc(m_epc), .m_cause(m_cause), .m_tval(m_tval),
        .u_epc(u_epc), .u_cause(u_cause), .u_tval(u_tval), .dbg_pc(dbg_pc),
        .dbg_csr(dbg_csr)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h (seq %0d)", req, what, act, exp, seq);
        end
    endtask

    // Compare every register output against the model.
    task automatic chk_regs(input string t_epc, input string t_cause,
                            input string t_tval, input string t_dbg, input string t_priv);
        chk(t_priv,  "priv_o",  {29'b0, priv_o}, {29'b0, e_priv});
        chk(t_epc,   "m_epc",   m_epc,   e_m_epc);
        chk(t_cause, "m_cause", m_cause, e_m_cause);
        chk(t_tval,  "m_tval",  m_tval,  e_m_tval);
        chk(t_epc,   "u_epc",   u_epc,   e_u_epc);
        chk(t_cause, "u_cause", u_cause, e_u_cause);
        chk(t_tval,  "u_tval",  u_tval,  e_u_tval);
        chk(t_dbg,   "dbg_pc",  dbg_pc,  e_dpc);
        chk(t_dbg,   "dbg_csr", dbg_csr, {16'b0, dbg_brk_en, 6'b0, e_dlow});
    endtask

    // Issue one trap, update the model, check the result, then check an idle cycle.
    task automatic do_trap(input logic [15:0] id, input logic [14:0] cause, input logic [1:0] pr);
        logic        exc, dbg, to_user;
        logic [14:0] c;
        logic [31:0] tv, base, cw;
        string       t_cause;
        seq++;
        @(negedge clk);
        trap_word   = {1'b0, cause, id};
        cur_priv    = pr;
        fault_pc    = 32'h0001_0000 + 32'(seq) * 4;
        fault_addr  = 32'h8000_0000 ^ (32'(seq) * 32'h0001_0101);
        fault_instr = seq[0] ? 32'hCAFE_0073 : 32'h1234_5672;
        trap_req    = 1'b1;
        exc = (id == 16'h0);
        c   = (exc && cause == 15'd11) ? 15'd8 + 15'(pr) : cause;
        t_cause = (exc && cause == 15'd11) ? "R3" : "R5";
        dbg = exc && c == 15'd3 && dbg_brk_en;
        to_user = exc && pr != 2'd3 && c < 15'd32 && deleg_mask[c[4:0]];
        if (!exc)                     tv = 32'h0;
        else if (c == 15'd2)          tv = (fault_instr[1:0] == 2'b11) ? fault_instr : {16'h0, fault_instr[15:0]};
        else if (c == 15'd3)          tv = dbg ? 32'h0 : fault_addr;
        else if (c < 15'd8)           tv = fault_addr;
        else                          tv = 32'h0;
        cw = {~exc, 16'h0, c};
        if (dbg) begin
            e_dpc  = fault_addr;
            e_dlow = 9'h043;
            e_priv = {1'b1, pr};
            base   = mvec;
        end else if (to_user) begin
            e_u_epc = fault_pc; e_u_cause = cw; e_u_tval = tv;
            e_priv  = 3'd0;
            base    = uvec;
        end else begin
            e_m_epc = fault_pc; e_m_cause = cw; e_m_tval = tv;
            e_priv  = 3'd3;
            base    = mvec;
        end
        e_pc = {base[31:2], 2'b00} + ((!exc && base[0]) ? {15'h0, c, 2'b00} : 32'h0);
        @(negedge clk);
        trap_req = 1'b0;
        chk("R2", "redirect_vld", {31'b0, redirect_vld}, 32'h1);
        chk("R8", "redirect_pc", redirect_pc, e_pc);
        chk_regs("R5", t_cause, "R6", "R7", dbg ? "R7" : "R4");
        @(negedge clk);
        chk("R2", "idle redirect_vld", {31'b0, redirect_vld}, 32'h0);
        chk_regs("R2", "R2", "R2", "R2", "R2");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state, checked while reset is still asserted.
        chk("R1", "reset redirect_vld", {31'b0, redirect_vld}, 32'h0);
        chk_regs("R1", "R1", "R1", "R1", "R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "post-reset redirect_vld", {31'b0, redirect_vld}, 32'h0);
        chk_regs("R1", "R1", "R1", "R1", "R1");

        uvec = 32'h0000_2003;
        // Exception sweep: debug enable x mask pattern x privilege x cause.
        for (int d = 0; d < 2; d++) begin
            dbg_brk_en = d[0];
            for (int m = 0; m < 2; m++) begin
                deleg_mask = m[0] ? 32'h0000_5A5A : 32'h0000_A5A5;
                mvec = m[0] ? 32'h0000_4001 : 32'h0000_4002;
                for (int p = 0; p < 4; p++) begin
                    if (p == 2) continue;
                    for (int c = 0; c < 16; c++)
                        do_trap(16'h0, 15'(c), 2'(p));
                end
            end
        end

        // Interrupt sweep: direct and vectored machine base, several identifiers.
        dbg_brk_en = 1'b1;
        deleg_mask = 32'hFFFF_FFFF;
        for (int v = 0; v < 2; v++) begin
            mvec = v[0] ? 32'h0000_8003 : 32'h0000_8002;
            for (int p = 0; p < 4; p += 3) begin
                for (int c = 0; c < 16; c++)
                    do_trap(c[0] ? 16'h8000 : 16'h0001, 15'(c), 2'(p));
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule